// File: doc/BRIEF.md
# Eight-Bit Function Unit with Status Flags

This block is the combinational function stage of a small datapath. Two operands, `opnd_a` and `opnd_b`, and a four-bit operation code enter it. One result word and four status flags leave it in the same cycle. It has no clock and no state. The surrounding datapath places register contents on the operand inputs and writes the result back in the same clock period. The control sequencer reads the flags.

Inside the unit are three sections:
- an adder section, built as a carry-ripple chain;
- a bitwise logic section;
- a single-position shifter that acts only on the second operand.

The top bits of the operation code select which section drives the result. Carry and overflow come from the adder section. Zero and negative are taken from whichever result leaves the unit.

Top module: `fu_core`

## Requirements
- R1: For codes 0000 to 0111 the result is (A + Y + k) mod 2^W. Code bit 0 is the carry-in k. Code bits [2:1] choose Y: 00 gives zero, 01 gives B, 10 gives the inverse of B, 11 gives all ones. So 0000=A, 0001=A+1, 0010=A+B, 0011=A+B+1, 0100=A+~B, 0101=A−B, 0110=A−1, 0111=A.
- R2: For codes 0000 to 0111, `flag_c` equals the carry out of the top bit of that sum.
- R3: For codes 0000 to 0111, `flag_v` is 1 exactly when A and Y have the same sign bit and the sign bit of the result differs from it.
- R4: Code 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives NOT A.
- R5: Code 1100 passes B through unchanged. Code 1101 shifts B right by one and puts 0 into the MSB. Code 1110 shifts B left by one and puts 0 into the LSB.
- R6: Code 1111 drives a result of all zeros.
- R7: For every code with bit 3 set, `flag_c` and `flag_v` are 0.
- R8: `flag_z` is 1 exactly when the result is all zeros, for every code.
- R9: `flag_n` equals the MSB of the result, for every code.
- R10: For codes 1100 to 1111, operand A has no effect on the result or on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fsel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand, also the shifter input |
| result | output | 8 | Function unit output |
| flag_c | output | 1 | Carry out of the adder |
| flag_v | output | 1 | Signed overflow of the adder |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result MSB |

## Verification
The adder codes are each driven with operand pairs that separate unsigned carry from signed overflow:
- 0x7F+1 sets overflow without carry.
- 0xFF+1 sets carry and zero without overflow.
- 0x80−1 sets both overflow and carry.
- Equal operands under subtraction give zero with carry set.

The logic codes use complementary and overlapping bit patterns, so that each operator gives a distinct answer. The shift codes use patterns with the MSB and LSB set, so that the dropped bit and the zero fill are both visible. Each shift code is repeated with two different values of A to show that A is ignored.

// File: rtl/fu_pkg.sv
package fu_pkg;

   // Section chosen by code bits [3:2]
   typedef enum logic [1:0] {
      GRP_ADD_LO = 2'b00,
      GRP_ADD_HI = 2'b01,
      GRP_BITOP  = 2'b10,
      GRP_SHIFT  = 2'b11
   } fu_group_e;

   // Bitwise operator chosen by code bits [1:0]
   typedef enum logic [1:0] {
      BOP_AND = 2'b00,
      BOP_OR  = 2'b01,
      BOP_XOR = 2'b10,
      BOP_NOT = 2'b11
   } fu_bitop_e;

   // Shifter operation chosen by code bits [1:0]
   typedef enum logic [1:0] {
      SH_PASS  = 2'b00,
      SH_RIGHT = 2'b01,
      SH_LEFT  = 2'b10,
      SH_RSVD  = 2'b11
   } fu_shift_e;

endpackage

// File: rtl/fu_adder.sv
module fu_adder #(
   parameter int  WIDTH      = 8,
   parameter bit  USE_RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       ysel,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] y;
   logic             c_into_msb;
   logic             c_out_msb;

   // Per-bit operand-B conditioning: ysel[0] keeps B, ysel[1] keeps ~B
   for (genvar i = 0; i < WIDTH; i++) begin : g_ybit
      assign y[i] = (b[i] & ysel[0]) | (~b[i] & ysel[1]);
   end

   if (USE_RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         assign sum[i]  = a[i] ^ y[i] ^ cy[i];
         assign cy[i+1] = (a[i] & y[i]) | (a[i] & cy[i]) | (y[i] & cy[i]);
      end
      assign c_into_msb = cy[MSB];
      assign c_out_msb  = cy[WIDTH];
   end else begin : g_flat
      logic [WIDTH:0] full;
      logic [MSB:0]   low;
      assign full = {1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
      assign low  = {1'b0, a[MSB-1:0]} + {1'b0, y[MSB-1:0]} + {{MSB{1'b0}}, cin};
      assign sum        = full[MSB:0];
      assign c_out_msb  = full[WIDTH];
      assign c_into_msb = low[MSB];
   end

   assign cout = c_out_msb;
   assign ovf  = c_out_msb ^ c_into_msb;

   // Checks against a plain wide addition and a sign-based overflow rule
   always_comb begin
      p_sum_r1: assert ({cout, sum} ==
                        ({1'b0, a} + {1'b0, y} + {{WIDTH{1'b0}}, cin}))
         else $error("adder sum/carry mismatch");
      p_no_overflow_r3: assert (ovf == ((a[MSB] == y[MSB]) && (sum[MSB] != a[MSB])))
         else $error("adder overflow mismatch");
   end
endmodule

// File: rtl/fu_bitop.sv
module fu_bitop
   import fu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  fu_bitop_e        op,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (op)
         BOP_AND: y = a & b;
         BOP_OR:  y = a | b;
         BOP_XOR: y = a ^ b;
         BOP_NOT: y = ~a;
         default: y = '0;
      endcase
   end

   // NOT never agrees with A in any bit
   always_comb begin
      if (op == BOP_NOT)
         p_not_r4: assert ((y & a) == '0) else $error("NOT kept a bit of A");
   end
endmodule

// File: rtl/fu_shift.sv
module fu_shift
   import fu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] b,
   input  fu_shift_e        op,
   output logic [WIDTH-1:0] y
);
   localparam int MSB = WIDTH - 1;

   always_comb begin
      unique case (op)
         SH_PASS:  y = b;
         SH_RIGHT: y = {1'b0, b[MSB:1]};
         SH_LEFT:  y = {b[MSB-1:0], 1'b0};
         default:  y = '0;
      endcase
   end

   // Vacated bit holds zero and the kept bits match their neighbours
   always_comb begin
      if (op == SH_RIGHT)
         p_rfill_r5: assert (!y[MSB] && (y[0] == b[1])) else $error("right shift fill");
      if (op == SH_LEFT)
         p_lfill_r5: assert (!y[0] && (y[MSB] == b[MSB-1])) else $error("left shift fill");
   end
endmodule

// File: rtl/fu_core.sv
module fu_core
   import fu_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit USE_RIPPLE = 1'b1
) (
   input  logic [3:0]       fsel,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   output logic [WIDTH-1:0] result,
   output logic             flag_c,
   output logic             flag_v,
   output logic             flag_z,
   output logic             flag_n
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_chk_width
      $error("fu_core: WIDTH must be at least 2");
   end

   fu_group_e        grp;
   logic [WIDTH-1:0] add_y, bit_y, sh_y;
   logic             add_c, add_v;

   assign grp = fu_group_e'(fsel[3:2]);

   fu_adder #(.WIDTH(WIDTH), .USE_RIPPLE(USE_RIPPLE)) u_adder (
      .a    (opnd_a),
      .b    (opnd_b),
      .ysel (fsel[2:1]),
      .cin  (fsel[0]),
      .sum  (add_y),
      .cout (add_c),
      .ovf  (add_v)
   );

   fu_bitop #(.WIDTH(WIDTH)) u_bitop (
      .a  (opnd_a),
      .b  (opnd_b),
      .op (fu_bitop_e'(fsel[1:0])),
      .y  (bit_y)
   );

   fu_shift #(.WIDTH(WIDTH)) u_shift (
      .b  (opnd_b),
      .op (fu_shift_e'(fsel[1:0])),
      .y  (sh_y)
   );

   always_comb begin
      result = add_y;
      flag_c = add_c;
      flag_v = add_v;
      unique case (grp)
         GRP_ADD_LO, GRP_ADD_HI: ;
         GRP_BITOP: begin
            result = bit_y;
            flag_c = 1'b0;
            flag_v = 1'b0;
         end
         default: begin
            result = sh_y;
            flag_c = 1'b0;
            flag_v = 1'b0;
         end
      endcase
   end

   assign flag_z = ~|result;
   assign flag_n = result[MSB];

   always_comb begin
      if (fsel[3])
         p_cv_clear_r7: assert (!flag_c && !flag_v) else $error("C/V set on non-add code");
      if (fsel == 4'b1111)
         p_rsvd_zero_r6: assert ((result == '0) && flag_z && !flag_n)
            else $error("reserved code not zero");
      if (flag_n)
         p_neg_nonzero_r9: assert (!flag_z) else $error("N and Z both set");
      if (fsel == 4'b0111)
         p_pass_a_r1: assert (result == opnd_a) else $error("A+ones+1 differs from A");
   end
endmodule

// File: tb/fu_core_tb.sv
module fu_core_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] fsel = '0;
   logic [7:0] opnd_a = '0, opnd_b = '0;
   logic [7:0] result;
   logic       flag_c, flag_v, flag_z, flag_n;
   int         n_chk = 0, n_bad = 0;

   always #10 clk = ~clk;   // 50 MHz

   fu_core u_dut (
      .fsel(fsel), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .result(result), .flag_c(flag_c), .flag_v(flag_v),
      .flag_z(flag_z), .flag_n(flag_n)
   );

   // Expected outputs from the requirement text, packed {f, c, v, z, n}
   function automatic logic [11:0] model(input logic [3:0] f, input logic [7:0] a, b);
      logic [7:0] r, y;
      logic [8:0] s;
      logic c, v;
      c = 1'b0; v = 1'b0; r = '0;
      if (!f[3]) begin
         case (f[2:1])
            2'b00: y = 8'h00;
            2'b01: y = b;
            2'b10: y = ~b;
            default: y = 8'hFF;
         endcase
         s = {1'b0, a} + {1'b0, y} + {8'd0, f[0]};
         r = s[7:0];
         c = s[8];
         v = (a[7] == y[7]) && (r[7] != a[7]);
      end else begin
         case (f[2:0])
            3'b000: r = a & b;
            3'b001: r = a | b;
            3'b010: r = a ^ b;
            3'b011: r = ~a;
            3'b100: r = b;
            3'b101: r = b >> 1;
            3'b110: r = b << 1;
            default: r = 8'h00;
         endcase
      end
      return {r, c, v, (r == 8'h00), r[7]};
   endfunction

   task automatic apply(input logic [3:0] f, input logic [7:0] a, b, input string req);
      logic [11:0] exp, got;
      @(posedge clk);
      fsel = f; opnd_a = a; opnd_b = b;
      @(negedge clk);
      exp = model(f, a, b);
      got = {result, flag_c, flag_v, flag_z, flag_n};
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s fs=%b a=%h b=%h: got f=%h cvzn=%b expected f=%h cvzn=%b",
                  req, f, a, b, got[11:4], got[3:0], exp[11:4], exp[3:0]);
      end
   endtask

   task automatic t_reset_state();
      // zero inputs under bench reset: result 0, only Z set (R8)
      apply(4'b0000, 8'h00, 8'h00, "R8 reset");
   endtask

   task automatic t_adder();
      apply(4'b0000, 8'h5A, 8'h33, "R1 pass A");
      apply(4'b0001, 8'hFF, 8'h00, "R2 A+1 carry, R8 zero");
      apply(4'b0010, 8'h7F, 8'h01, "R3 A+B overflow, R9 neg");
      apply(4'b0010, 8'hFF, 8'h01, "R2 A+B carry");
      apply(4'b0011, 8'h10, 8'h20, "R1 A+B+1");
      apply(4'b0100, 8'h05, 8'h03, "R1 A+~B");
      apply(4'b0101, 8'h05, 8'h03, "R1 A-B");
      apply(4'b0101, 8'h44, 8'h44, "R2 A-B equal, R8");
      apply(4'b0101, 8'h80, 8'h01, "R3 A-B overflow");
      apply(4'b0101, 8'h03, 8'h05, "R2 A-B borrow");
      apply(4'b0110, 8'h80, 8'h00, "R3 A-1 overflow");
      apply(4'b0110, 8'h00, 8'h00, "R2 A-1 no carry");
      apply(4'b0111, 8'hC3, 8'h00, "R1 A via ones+1");
   endtask

   task automatic t_bitop();
      apply(4'b1000, 8'hF0, 8'hCC, "R4 AND, R7");
      apply(4'b1001, 8'hF0, 8'hCC, "R4 OR, R9");
      apply(4'b1010, 8'hF0, 8'hCC, "R4 XOR");
      apply(4'b1010, 8'hA5, 8'hA5, "R4 XOR zero, R8");
      apply(4'b1011, 8'hF0, 8'hCC, "R4 NOT A");
   endtask

   task automatic t_shifter();
      for (int k = 0; k < 2; k++) begin
         logic [7:0] a_var;
         a_var = (k == 0) ? 8'h00 : 8'hFF;   // R10: A must not matter
         apply(4'b1100, a_var, 8'h81, "R5 pass B, R10");
         apply(4'b1101, a_var, 8'h81, "R5 right zero fill, R10");
         apply(4'b1110, a_var, 8'h81, "R5 left zero fill, R10, R7");
         apply(4'b1110, a_var, 8'h40, "R5 left into MSB, R9");
      end
   endtask

   task automatic t_reserved();
      apply(4'b1111, 8'hFF, 8'hFF, "R6 reserved zero, R10");
      apply(4'b1111, 8'h12, 8'h34, "R6 reserved zero");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (2) @(posedge clk);
      t_reset_state();
      rst = 1'b0;
      t_adder();
      t_bitop();
      t_shifter();
      t_reserved();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule